// File: doc/BRIEF.md
# Inter-Processor Interrupt Register Block

This block lets one processor raise an interrupt towards a host and tell the receiver who raised it. Software sets source flags and fires the interrupt through a generation register. The receiver reads those flags and acknowledges them through a separate acknowledgement register, which clears flags with write-one-to-clear semantics. The flag storage is shared: both registers read back the same set of flags.

Firing the trigger bit produces a stretched pulse on a single host interrupt output. The output is high for four clocks and then low for four clocks. While such a pulse is in progress, further triggers are ignored. The flags are still updated by those ignored writes. A trigger that arrives on the first clock after the eight-clock window is accepted, so pulses can follow each other back to back.

The register bus is a plain synchronous port with an address, a write strobe, write data and registered read data. Read data returns one clock after the address is presented.

Top module: `ipi_regblock`

## Requirements
- R1: After a synchronous reset all source flags are 0, the host output is 0 and the read data is 0.
- R2: Reading the generation register at byte address 0x0 returns source flag n at bit n+4 (for n from 0 to 27). Bits 3 to 0 read as 0, and that includes the trigger bit 0.
- R3: Reading the acknowledgement register at byte address 0x4 returns the same source flags at bits 31 to 4, with bits 3 to 0 reading as 0.
- R4: A write to address 0x0 sets every source flag whose bit (n+4) is 1 and leaves the flags whose bit is 0 unchanged. Bits 3 to 1 are ignored.
- R5: A write to address 0x4 clears every source flag whose bit (n+4) is 1, as seen through both registers. Zero bits and bits 3 to 0 have no effect.
- R6: A write to address 0x0 with bit 0 set, made while no pulse is in progress, drives the host output high for the 4 clocks after the write edge and then low for 4 clocks.
- R7: A trigger written in the 7 clocks following an accepted trigger produces no pulse and does not extend the current one. The source bits of that write are still set.
- R8: A trigger written exactly 8 clocks after the previously accepted trigger is accepted. The host output then goes from the fourth low clock straight into a new 4-clock high phase.
- R9: Read data is registered. It appears on the clock after the address and shows the flags as they stood before any write on that same edge. Any other address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per high clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous address |
| host_irq | output | 1 | Stretched host interrupt pulse |

## Verification
The bench fires triggers at three offsets from an accepted one. A trigger at 3 clocks is blocked, and so is one at 7 clocks, the last blocked offset. A trigger at 8 clocks is accepted. A design with an off-by-one window would either lengthen the low phase or emit an extra pulse. The bench checks that an acknowledgement write clears flags through both addresses while leaving the reserved bits and the zero bits alone. A design that treated the register as a plain store would overwrite the flags instead. It also checks that flags written together with a blocked trigger still stick, and that read data lags the address by exactly one clock. A combinational read port would show the new flags one clock too early.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_GEN  = 2'd1,
    SEL_ACK  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/ipi_bus_decode.sv
module ipi_bus_decode
  import ipi_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_SRC  = 28,
  parameter int SRC_LSB  = 4,
  parameter logic [ADDR_W-1:0] GEN_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] ACK_ADDR = 4'h4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  output reg_sel_e           sel,
  output logic [NUM_SRC-1:0] set_vec,
  output logic [NUM_SRC-1:0] clr_vec,
  output logic               trig
);

  logic [NUM_SRC-1:0] src_field;
  logic               unused_rsvd;

  assign src_field   = wdata[SRC_LSB +: NUM_SRC];
  assign unused_rsvd = ^wdata[SRC_LSB-1:1];

  always_comb begin
    if (addr == GEN_ADDR)      sel = SEL_GEN;
    else if (addr == ACK_ADDR) sel = SEL_ACK;
    else                       sel = SEL_NONE;
  end

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    trig    = 1'b0;
    if (wr) begin
      case (sel)
        SEL_GEN: begin
          set_vec = src_field;
          trig    = wdata[0];
        end
        SEL_ACK: clr_vec = src_field;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ipi_src_flags.sv
module ipi_src_flags #(
  parameter int NUM_SRC = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] flags
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end

    // R4: a set request lands on the next edge
    a_r4_set_sticks: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> flags[i]);
    // R5: a clear request without a set empties the flag
    a_r5_clear_wins_alone: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[i] && !set_vec[i]) |=> !flags[i]);
    // R5: with no request the flag holds
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
      (!clr_vec[i] && !set_vec[i]) |=> $stable(flags[i]));
  end

endmodule

// File: rtl/ipi_pulse_gen.sv
module ipi_pulse_gen #(
  parameter int HIGH_CYC = 4,
  parameter int LOW_CYC  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic host_irq
);

  localparam int TOTAL = HIGH_CYC + LOW_CYC;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] HI_END = CNT_W'(HIGH_CYC);

  logic [CNT_W-1:0] cnt, cnt_n;
  logic             accept;

  assign accept = trig && ((cnt == '0) || (cnt == LAST));

  always_comb begin
    if (accept)           cnt_n = CNT_W'(1);
    else if (cnt == LAST) cnt_n = '0;
    else if (cnt != '0)   cnt_n = cnt + CNT_W'(1);
    else                  cnt_n = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      host_irq <= 1'b0;
    end else begin
      cnt      <= cnt_n;
      host_irq <= (cnt_n != '0) && (cnt_n <= HI_END);
    end
  end

  // R6: an accepted trigger raises the output on the next edge
  a_r6_rise_on_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> host_irq);
  // R6: the high phase ends after its last count
  a_r6_high_ends: assert property (@(posedge clk) disable iff (rst)
    (cnt == HI_END && !trig) |=> !host_irq);
  // R7: inside the window a pulse is never restarted
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && cnt != LAST) |=> (cnt != CNT_W'(1)));
  // R8: a trigger on the closing count restarts the pulse
  a_r8_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST && trig) |=> (host_irq && cnt == CNT_W'(1)));

endmodule

// File: rtl/ipi_read_port.sv
module ipi_read_port
  import ipi_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 28,
  parameter int SRC_LSB = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] flags,
  output logic [DATA_W-1:0]  rdata
);

  logic [DATA_W-1:0] rd_n;

  always_comb begin
    rd_n = '0;
    if (sel != SEL_NONE) rd_n[SRC_LSB +: NUM_SRC] = flags;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

  // R2 / R3: low field never carries data
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[SRC_LSB-1:0] == '0);
  // R9: an unmapped address reads zero one clock later
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (rdata == '0));

endmodule

// File: rtl/ipi_regblock.sv
module ipi_regblock
  import ipi_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_SRC  = 28,
  parameter int HIGH_CYC = 4,
  parameter int LOW_CYC  = 4,
  parameter logic [ADDR_W-1:0] GEN_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] ACK_ADDR = 4'h4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              host_irq
);

  localparam int SRC_LSB = DATA_W - NUM_SRC;

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] set_vec, clr_vec, flags;
  logic               trig;

  ipi_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SRC_LSB(SRC_LSB),
    .GEN_ADDR(GEN_ADDR), .ACK_ADDR(ACK_ADDR)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .sel(sel), .set_vec(set_vec), .clr_vec(clr_vec), .trig(trig)
  );

  ipi_src_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
  );

  ipi_pulse_gen #(.HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC)) u_pulse (
    .clk(clk), .rst(rst), .trig(trig), .host_irq(host_irq)
  );

  ipi_read_port #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SRC_LSB(SRC_LSB)) u_rd (
    .clk(clk), .rst(rst), .sel(sel), .flags(flags), .rdata(bus_rdata)
  );

  // R1: reset leaves the outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && !host_irq));

endmodule

// File: tb/ipi_regblock_test.sv
module ipi_regblock_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        host_irq;

  ipi_regblock uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference
  logic [27:0] m_flags = '0;
  bit          m_busy = 1'b0;
  int          m_age = 0;
  int          m_pulses = 0;
  int          seen_rises = 0;
  logic [31:0] exp_rd = '0;
  logic        exp_irq = 1'b0;
  logic        prev_irq = 1'b0;

  always @(posedge clk) begin
    logic trig_now;
    trig_now = 1'b0;
    cycles++;
    if (rst) begin
      exp_rd  = '0;
      m_flags = '0;
      m_busy  = 1'b0;
      m_age   = 0;
    end else begin
      exp_rd = (bus_addr == 4'h0 || bus_addr == 4'h4) ? {m_flags, 4'h0} : 32'h0;
      if (bus_wr && bus_addr == 4'h0) begin
        m_flags  = m_flags | bus_wdata[31:4];
        trig_now = bus_wdata[0];
      end else if (bus_wr && bus_addr == 4'h4) begin
        m_flags = m_flags & ~bus_wdata[31:4];
      end
      if (trig_now && (!m_busy || m_age >= 7)) begin
        m_busy = 1'b1;
        m_age  = 0;
        m_pulses++;
      end else if (m_busy) begin
        m_age++;
        if (m_age >= 8) m_busy = 1'b0;
      end
    end
    exp_irq = m_busy && (m_age < 4);
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // per-clock comparison, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      check(bus_rdata, exp_rd, "read data");
      check({31'b0, host_irq}, {31'b0, exp_irq}, "host output");
      if (host_irq && !prev_irq) seen_rises++;
      prev_irq = host_irq;
    end
  end

  initial begin
    @(negedge clk);
    wait (cycles > WATCHDOG);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R4 + R2: set flags, reserved bits 3..1 ignored, trigger bit clear
    cur_req = "R4";
    wr(4'h0, 32'hA5A5_A5FE);
    cur_req = "R2";
    bus_addr = 4'h0;
    idle(2);
    cur_req = "R3";
    bus_addr = 4'h4;
    idle(2);
    // R4: zeros leave earlier flags alone
    cur_req = "R4";
    wr(4'h0, 32'h0000_0010);
    idle(2);

    // R5: clear some flags, reserved and zero bits have no effect
    cur_req = "R5";
    wr(4'h4, 32'h0F00_00FF);
    bus_addr = 4'h0;
    idle(2);
    wr(4'h4, 32'h0000_0000);
    bus_addr = 4'h4;
    idle(2);

    // R6: single pulse, 4 high then 4 low
    cur_req = "R6";
    wr(4'h0, 32'h0000_0001);
    idle(10);

    // R7: trigger 3 clocks into the window is ignored, its flag still sets
    cur_req = "R7";
    wr(4'h0, 32'h0000_0001);
    idle(2);
    wr(4'h0, 32'h8000_0001);
    bus_addr = 4'h4;
    idle(10);
    // R7: trigger at offset 7, the last blocked clock
    wr(4'h0, 32'h0000_0001);
    idle(6);
    wr(4'h0, 32'h0000_0021);
    idle(10);

    // R8: trigger exactly 8 clocks after the last accepted one
    cur_req = "R8";
    wr(4'h0, 32'h0000_0001);
    idle(7);
    wr(4'h0, 32'h0000_0001);
    idle(10);

    // R9: unmapped address reads zero and ignores writes
    cur_req = "R9";
    wr(4'h8, 32'hFFFF_FFFF);
    bus_addr = 4'h8;
    idle(2);
    bus_addr = 4'h0;
    idle(2);
    // R9: read data lags, a write on the read edge is shown one clock later
    wr(4'h0, 32'h0F00_0000);
    idle(1);
    wr(4'h4, 32'hFFFF_FFF0);
    idle(2);

    // R7: pulse count agrees with accepted triggers
    cur_req = "R7";
    check(seen_rises, m_pulses, "pulse count");
    check(m_pulses, 5, "accepted triggers");

    done = 1'b1;
    finish_run();
  end

endmodule